// File: doc/BRIEF.md
# Flash Embedded-Operation Status Word Generator

This block forms the byte that a host read returns from a NOR-style flash while an internal program or erase algorithm is running, and it drives the ready/busy line. The command decoder tells it which operation is active. The program datapath supplies the top bit of the value being written. The erase sequencer supplies whether the current read address falls in a block that is selected for erase, whether the erase has failed, and whether the window for adding more blocks is still open. When nothing is running, the block passes the array read data straight through.

Each status bit tracks its own piece of progress. The top bit is a polling flag. Two bits flip on every completed read, one for any active operation and one for reads inside blocks being erased. One bit flags errors, one reports whether the erase has really started, and the reserved bits read 0. The flip-flops behind the two toggling bits change only when a read strobe ends, so a word stays stable for the whole of one read. If an erase selects only protected blocks, the status word is shown for a fixed number of clocks and then the array data returns.

Top module: `flash_status_gen`

## Requirements
- R1: With op_mode = 1 (program), status bit 7 is the inverse of prog_bit7, and bit 3 is 0.
- R2: With op_mode = 2 (erase), status bit 7 is 0. With op_mode = 0 (idle), status equals array_data, which is how the final programmed or erased data appears once an operation has finished.
- R3: While a program is running, or an erase that is not in the all-protected pass-through, status bit 6 inverts once for every read. The change takes effect one clock after rd_strobe falls, so the value is constant while rd_strobe is high.
- R4: Status bit 6 does not change on reads made while idle or suspended, and it keeps its value across a suspend.
- R5: During program or erase, status bit 5 equals err_flag. In a suspended read of an erasing block it reads 0.
- R6: During erase, status bit 3 is 0 while win_open is 1 and 1 once win_open is 0. In a suspended read of an erasing block it reads 1.
- R7: Status bit 2 inverts at the end of each read made during erase or suspend (op_mode = 3) whose address has in_erase_blk = 1. It holds on reads of other blocks and during program.
- R8: With op_mode = 3, a read with in_erase_blk = 1 returns bit 7 = 1, so bit 7 goes from 0 to 1 when the suspend begins. A read with in_erase_blk = 0 returns array_data.
- R9: If all_prot is 1 when op_mode enters erase, the status word with bit 7 = 0 is shown and ready stays low for PROT_CYCLES clocks after the first clock edge in erase. From then on, until erase ends, status equals array_data and ready is 1.
- R10: ready is 0 during program and during erase that is not in the all-protected pass-through. It is 1 when idle and when suspended.
- R11: Whenever a status word, rather than array data, is returned, bits 0, 1 and 4 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_mode | input | 2 | 0 idle, 1 program, 2 erase, 3 erase suspended |
| prog_bit7 | input | 1 | Bit 7 of the value being programmed |
| in_erase_blk | input | 1 | Read address lies in a block selected for erase |
| err_flag | input | 1 | Operation failure reported by the algorithm |
| win_open | input | 1 | Window for adding erase blocks still open |
| all_prot | input | 1 | Every block selected for erase is protected |
| rd_strobe | input | 1 | High for the duration of one host read |
| array_data | input | 8 | Data read from the array |
| status | output | 8 | Byte returned to the host read |
| ready | output | 1 | High when no program or erase is running |

## Verification
Random reads are spread over all four operation codes, with random write bits, block membership, error and window flags, and array data. This separates the polling, error and window bits, which depend on the operation code, from the pass-through cases, and it shows whether bit 2 follows block membership while bit 6 does not. Long runs of reads in a single mode check that each toggle flips exactly once per read and never in the middle of one. A directed program, then erase, then suspend sequence checks the 0-to-1 change of bit 7 and that bit 6 holds across the suspend. A directed all-protected erase is sampled on the last clock of the hold interval and on the first clock after it, to check where the status word ends and array data returns.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PROG = 2'd1,
    OP_ERASE = 2'd2,
    OP_SUSP = 2'd3
  } op_t;

  localparam int STAT_W = 8;

  // Assemble the status byte in its fixed bit positions.
  function automatic logic [STAT_W-1:0] pack_status(
    input logic poll, input logic tog_any, input logic fail,
    input logic started, input logic tog_blk);
    logic [STAT_W-1:0] w;
    w = '0;
    w[7] = poll;
    w[6] = tog_any;
    w[5] = fail;
    w[3] = started;
    w[2] = tog_blk;
    return w;
  endfunction

  // Is an algorithm actively running (toggle bit 6 advances)?
  function automatic logic op_running(input op_t op, input logic prot_done);
    return (op == OP_PROG) || ((op == OP_ERASE) && !prot_done);
  endfunction
endpackage

// File: rtl/read_trail_det.sv
module read_trail_det (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_strobe,
  output logic trail
);
  logic rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= 1'b0;
    else        rd_q <= rd_strobe;
  end

  assign trail = rd_q & ~rd_strobe;
endmodule

// File: rtl/toggle_cell.sv
module toggle_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic trail,
  input  logic enable,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                q <= 1'b0;
    else if (trail && enable)  q <= ~q;
  end

  // R3 / R7: a qualified read end flips the bit on the next edge
  a_r3_flip_on_trail: assert property (@(posedge clk) disable iff (!rst_n)
    (trail && enable) |=> (q != $past(q)));
  // R4 / R7: no qualified read end, no change
  a_r4_hold_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
    !(trail && enable) |=> $stable(q));
endmodule

// File: rtl/prot_hold_timer.sv
module prot_hold_timer #(
  parameter int PROT_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_erase,
  input  logic all_prot,
  output logic prot_done
);
  localparam int CNT_W = $clog2(PROT_CYCLES + 1);

  logic             erase_q;
  logic             prot_lat;
  logic [CNT_W-1:0] cnt;
  logic             erase_entry;

  assign erase_entry = in_erase && !erase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      erase_q  <= 1'b0;
      prot_lat <= 1'b0;
      cnt      <= '0;
    end else begin
      erase_q <= in_erase;
      if (!in_erase) begin
        prot_lat <= 1'b0;
        cnt      <= '0;
      end else if (erase_entry) begin
        prot_lat <= all_prot;
        cnt      <= all_prot ? CNT_W'(PROT_CYCLES) : '0;
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign prot_done = in_erase && prot_lat && (cnt == '0);

  // R9: counter never leaves its range
  a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(PROT_CYCLES));
  // R9: once pass-through starts it lasts while erase lasts
  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_done && in_erase) |=> (prot_done || !in_erase));
endmodule

// File: rtl/status_compose.sv
module status_compose
  import flash_status_pkg::*;
(
  input  op_t         op,
  input  logic        prog_bit7,
  input  logic        in_erase_blk,
  input  logic        err_flag,
  input  logic        win_open,
  input  logic        tog_any,
  input  logic        tog_blk,
  input  logic        prot_done,
  input  logic [7:0]  array_data,
  output logic [7:0]  status,
  output logic        show_status
);
  always_comb begin
    show_status = 1'b0;
    status      = array_data;
    unique case (op)
      OP_PROG: begin
        show_status = 1'b1;
        status = pack_status(~prog_bit7, tog_any, err_flag, 1'b0, tog_blk);
      end
      OP_ERASE: begin
        if (!prot_done) begin
          show_status = 1'b1;
          status = pack_status(1'b0, tog_any, err_flag, ~win_open, tog_blk);
        end
      end
      OP_SUSP: begin
        if (in_erase_blk) begin
          show_status = 1'b1;
          status = pack_status(1'b1, tog_any, 1'b0, 1'b1, tog_blk);
        end
      end
      default: begin
        show_status = 1'b0;
        status      = array_data;
      end
    endcase
  end
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import flash_status_pkg::*;
#(
  parameter int PROT_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] op_mode,
  input  logic       prog_bit7,
  input  logic       in_erase_blk,
  input  logic       err_flag,
  input  logic       win_open,
  input  logic       all_prot,
  input  logic       rd_strobe,
  input  logic [7:0] array_data,
  output logic [7:0] status,
  output logic       ready
);
  localparam int N_TOG = 2;

  op_t              op;
  logic             trail;
  logic             prot_done;
  logic             show_status;
  logic [N_TOG-1:0] tog_en;
  logic [N_TOG-1:0] tog_q;

  assign op = op_t'(op_mode);

  read_trail_det u_trail (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_strobe (rd_strobe),
    .trail     (trail)
  );

  prot_hold_timer #(.PROT_CYCLES(PROT_CYCLES)) u_prot (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_erase  (op == OP_ERASE),
    .all_prot  (all_prot),
    .prot_done (prot_done)
  );

  // index 0: toggle for any running algorithm; index 1: erasing-block toggle
  assign tog_en[0] = op_running(op, prot_done);
  assign tog_en[1] = in_erase_blk &&
                     (((op == OP_ERASE) && !prot_done) || (op == OP_SUSP));

  for (genvar g = 0; g < N_TOG; g++) begin : g_tog
    toggle_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .trail  (trail),
      .enable (tog_en[g]),
      .q      (tog_q[g])
    );
  end

  status_compose u_comp (
    .op           (op),
    .prog_bit7    (prog_bit7),
    .in_erase_blk (in_erase_blk),
    .err_flag     (err_flag),
    .win_open     (win_open),
    .tog_any      (tog_q[0]),
    .tog_blk      (tog_q[1]),
    .prot_done    (prot_done),
    .array_data   (array_data),
    .status       (status),
    .show_status  (show_status)
  );

  assign ready = !op_running(op, prot_done);

  // R10: program always busy
  a_r10_prog_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_PROG) |-> !ready);
  // R10: idle and suspend always ready
  a_r10_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == OP_IDLE) || (op == OP_SUSP)) |-> ready);
  // R11: reserved bits clear in every status word
  a_r11_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    show_status |-> (status[1:0] == 2'b00 && status[4] == 1'b0));
  // R2: idle passes array data unchanged
  a_r2_idle_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_IDLE) |-> (status == array_data));
  // R3: bit 6 constant while a read strobe is held
  a_r3_stable_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && $past(rd_strobe)) |-> $stable(tog_q));
endmodule

// File: tb/sim_flash_status_gen.sv
`timescale 1ns/1ps
module sim_flash_status_gen;
  localparam int PC = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] op_mode = 2'd0;
  logic       prog_bit7 = 1'b0, in_erase_blk = 1'b0, err_flag = 1'b0;
  logic       win_open = 1'b0, all_prot = 1'b0, rd_strobe = 1'b0;
  logic [7:0] array_data = 8'h00;
  logic [7:0] status;
  logic       ready;

  int checks = 0;
  int fails = 0;
  logic m6 = 1'b0;
  logic m2 = 1'b0;

  always #2.5 clk = ~clk;

  flash_status_gen #(.PROT_CYCLES(PC)) u0 (
    .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .prog_bit7(prog_bit7),
    .in_erase_blk(in_erase_blk), .err_flag(err_flag), .win_open(win_open),
    .all_prot(all_prot), .rd_strobe(rd_strobe), .array_data(array_data),
    .status(status), .ready(ready));

  function automatic logic [7:0] exp_word(input logic pdone);
    logic [7:0] w;
    w = array_data;
    case (op_mode)
      2'd1: begin
        w = 8'h00; w[7] = !prog_bit7; w[6] = m6; w[5] = err_flag; w[2] = m2;
      end
      2'd2: if (!pdone) begin
        w = 8'h00; w[6] = m6; w[5] = err_flag; w[3] = !win_open; w[2] = m2;
      end
      2'd3: if (in_erase_blk) begin
        w = 8'h00; w[7] = 1'b1; w[6] = m6; w[3] = 1'b1; w[2] = m2;
      end
      default: w = array_data;
    endcase
    return w;
  endfunction

  function automatic string tag_for(input logic [1:0] op);
    case (op)
      2'd1: return "R1";
      2'd2: return "R2";
      2'd3: return "R8";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one host read; called just after a negedge
  task automatic host_read(input logic pdone, input string req);
    rd_strobe = 1'b1;
    @(negedge clk);
    chk(req, {24'd0, status}, {24'd0, exp_word(pdone)});
    chk("R10", {31'd0, ready},
        {31'd0, !((op_mode == 2'd1) || (op_mode == 2'd2 && !pdone))});
    @(negedge clk);
    // R3: still unchanged in the second half of the read
    chk("R3", {31'd0, status[6]}, {31'd0, exp_word(pdone)} >> 6 & 32'd1);
    rd_strobe = 1'b0;
    @(negedge clk);
    if (op_mode == 2'd1 || (op_mode == 2'd2 && !pdone)) m6 = ~m6;
    if (in_erase_blk && ((op_mode == 2'd2 && !pdone) || op_mode == 2'd3)) m2 = ~m2;
  endtask

  initial begin
    #1000000;
    fails++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    array_data = 8'h5A;
    repeat (3) @(negedge clk);
    chk("R10", {31'd0, ready}, 32'd1);
    chk("R2", {24'd0, status}, 32'h5A);
    rst_n = 1'b1;
    @(negedge clk);

    // directed program, R1 / R3 / R5
    op_mode = 2'd1; prog_bit7 = 1'b1; err_flag = 1'b0;
    @(negedge clk);
    chk("R1", {31'd0, status[7]}, 32'd0);
    host_read(1'b0, "R1");
    chk("R3", {31'd0, status[6]}, {31'd0, m6});
    host_read(1'b0, "R3");
    err_flag = 1'b1;
    host_read(1'b0, "R5");
    // directed erase with window, R6 / R7
    op_mode = 2'd2; err_flag = 1'b0; win_open = 1'b1; in_erase_blk = 1'b1;
    @(negedge clk);
    chk("R6", {31'd0, status[3]}, 32'd0);
    host_read(1'b0, "R7");
    chk("R7", {31'd0, status[2]}, {31'd0, m2});
    win_open = 1'b0;
    host_read(1'b0, "R6");
    chk("R2", {31'd0, status[7]}, 32'd0);
    // suspend: bit 7 rises, bit 6 frozen, R8 / R4
    op_mode = 2'd3;
    @(negedge clk);
    chk("R8", {31'd0, status[7]}, 32'd1);
    host_read(1'b0, "R4");
    host_read(1'b0, "R4");
    chk("R4", {31'd0, status[6]}, {31'd0, m6});
    in_erase_blk = 1'b0; array_data = 8'hC3;
    host_read(1'b0, "R8");
    chk("R8", {24'd0, status}, 32'hC3);
    // idle: R2 / R10
    op_mode = 2'd0; array_data = 8'h81;
    @(negedge clk);
    chk("R2", {24'd0, status}, 32'h81);

    // all-protected erase, R9
    all_prot = 1'b1; op_mode = 2'd2; in_erase_blk = 1'b1; win_open = 1'b0;
    repeat (PC) @(posedge clk);
    @(negedge clk);
    chk("R9", {31'd0, ready}, 32'd0);
    chk("R9", {31'd0, status[7]}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R9", {31'd0, ready}, 32'd1);
    chk("R9", {24'd0, status}, 32'h81);
    host_read(1'b1, "R9");
    all_prot = 1'b0; op_mode = 2'd0;
    @(negedge clk);

    // random mixture; all_prot stays 0 so pass-through never triggers
    for (int it = 0; it < 200; it++) begin
      op_mode      = 2'($urandom % 4);
      prog_bit7    = 1'($urandom);
      in_erase_blk = 1'($urandom);
      err_flag     = 1'($urandom);
      win_open     = 1'($urandom);
      array_data   = 8'($urandom);
      @(negedge clk);
      for (int k = 0; k < 1 + int'($urandom % 3); k++) begin
        host_read(1'b0, tag_for(op_mode));
        if (op_mode != 2'd0 && !(op_mode == 2'd3 && !in_erase_blk))
          chk("R11", {29'd0, status[4], status[1:0]}, 32'd0);
        if (op_mode == 2'd2)
          chk("R5", {31'd0, status[5]}, {31'd0, err_flag});
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule